// File: doc/BRIEF.md
# Keyscan GPIO Port Pair

This block provides two 8-bit bidirectional parallel ports on a small register bus. Each port has an output latch and a direction register at its own address. A direction bit set to 1 drives the pin from the latch. A direction bit cleared to 0 makes the pin an input, and its level is sampled through a synchroniser. One of the two ports is a plain port.

The other port is a keyscan port. It has a static per-pin option vector. A pin whose option bit is set gets its pullup enabled. While that pin is an input, it also becomes an interrupt source. Enabled keyscan pins are merged with an external active-low interrupt line into one request.

That request follows one shared sensitivity mode, either falling edge only or edge plus level. It is gated by an interrupt-enable input. A one-cycle acknowledge pulse clears the latched edge.

Top module: `gpio_keyscan_port`

## Requirements
- R1: Register map, 3-bit address: plain port latch at 0, keyscan port latch at 1, plain port direction at 4, keyscan port direction at 5. A write updates only the addressed register. Reading a direction register returns its contents.
- R2: A direction bit of 1 drives the pin: the output-enable bit follows it on the cycle after the write, and the pin output equals the latch bit. A direction bit of 0 releases the pin.
- R3: Reset clears both direction registers, so every output enable is 0. Reset leaves both output latches unchanged.
- R4: Reading a latch address returns the latch bit for output pins. For input pins it returns the pin level after a two-stage synchroniser.
- R5: Addresses 2, 3, 6 and 7 are unmapped. Writes to them change no register, and reads from them return 0.
- R6: A falling edge on a keyscan pin whose option bit is 1 and that is an input sets a pending flag. While the interrupt enable is high, a set pending flag drives the request output to 1.
- R7: A keyscan pin whose option bit is 0, or that is configured as an output, never causes a request.
- R8: A falling edge on the external active-low interrupt line sets the same pending flag.
- R9: With the mode input at 0 (edge only), the request stays asserted after the line returns high until an acknowledge pulse. After the acknowledge it stays low, even while a line is still held low.
- R10: With the mode input at 1 (edge and level), the request stays asserted while any enabled line is low, whatever the acknowledge does.
- R11: With the interrupt enable low the request is 0. The pending flag is retained, and the request appears once the enable returns high.
- R12: A keyscan pin that switches from output to input while its level is low does not create an edge.
- R13: The pullup-enable output equals the static option vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 3 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the current address |
| pa_in_i | input | 8 | Plain port pad levels |
| pa_out_o | output | 8 | Plain port output values |
| pa_oe_o | output | 8 | Plain port output enables |
| pb_in_i | input | 8 | Keyscan port pad levels |
| pb_out_o | output | 8 | Keyscan port output values |
| pb_oe_o | output | 8 | Keyscan port output enables |
| pb_pullup_o | output | 8 | Keyscan port pullup enables |
| irq_ni | input | 1 | External interrupt line, active low |
| irq_level_mode_i | input | 1 | 0 = falling edge only, 1 = edge and level |
| irq_en_i | input | 1 | Interrupt enable gate |
| irq_ack_i | input | 1 | Acknowledge pulse, clears the pending edge |
| irq_req_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with a width of 8, two synchroniser stages and an option vector of 8'hA5. With that vector, pins with the option set (0, 2, 5) and pins without it (1) sit on one port, so the enabled and ignored interrupt paths are both exercised. The two-stage synchroniser gives a fixed three-cycle delay from a pad edge to the pending flag, and the bench samples against that delay. The same build also reaches the output-to-input switch with the pin held low, the level-mode hold and the gated request.

// File: rtl/gpio_kbd_pkg.sv
package gpio_kbd_pkg;
  localparam int unsigned OFF_PA_DATA = 0;
  localparam int unsigned OFF_PB_DATA = 1;
  localparam int unsigned OFF_PA_DIR  = 4;
  localparam int unsigned OFF_PB_DIR  = 5;

  typedef enum logic {
    SENSE_EDGE  = 1'b0,
    SENSE_LEVEL = 1'b1
  } sense_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W       = 8,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int unsigned W       = 8,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [ADDR_W-1:0] DATA_ADDR = '0,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      pin_i,
  output logic [W-1:0]      out_o,
  output logic [W-1:0]      oe_o,
  output logic [W-1:0]      sync_o
);
  logic [W-1:0] data_q;
  logic [W-1:0] dir_q;
  logic         wr_data, wr_dir;

  assign wr_data = wr_i && (addr_i == DATA_ADDR);
  assign wr_dir  = wr_i && (addr_i == DIR_ADDR);

  // latch has no reset: contents survive reset
  always_ff @(posedge clk_i) begin
    if (wr_data) data_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dir_q <= '0;
    else if (wr_dir) dir_q <= wdata_i;
  end

  gpio_sync #(.W(W), .STAGES(STAGES), .RST_VAL('1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_o)
  );

  assign out_o = data_q;
  assign oe_o  = dir_q;

  AST_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && (addr_i == DIR_ADDR) |=> oe_o == $past(wdata_i)); // R2
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && (addr_i == DATA_ADDR)) |=> $stable(out_o)); // R1
endmodule

// File: rtl/gpio_key_irq.sv
module gpio_key_irq #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] key_sync_i,
  input  logic [W-1:0] key_en_i,
  input  logic         irq_ni,
  input  logic         level_mode_i,
  input  logic         en_i,
  input  logic         ack_i,
  output logic         req_o
);
  import gpio_kbd_pkg::*;

  logic         irq_sync;
  logic         irq_prev_q;
  logic [W-1:0] key_prev_q;
  logic [W-1:0] key_en_prev_q;
  logic [W-1:0] key_fall;
  logic         ext_fall, any_fall, any_low;
  logic         pend_q;
  sense_e       mode;

  gpio_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b1)) u_irq_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_ni),
    .q_o   (irq_sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_prev_q    <= 1'b1;
      key_prev_q    <= '1;
      key_en_prev_q <= '0;
    end else begin
      irq_prev_q    <= irq_sync;
      key_prev_q    <= key_sync_i;
      key_en_prev_q <= key_en_i;
    end
  end

  // edge only between two consecutive input-mode samples
  assign key_fall = key_en_i & key_en_prev_q & key_prev_q & ~key_sync_i;
  assign ext_fall = irq_prev_q & ~irq_sync;
  assign any_fall = ext_fall | (|key_fall);
  assign any_low  = ~irq_sync | (|(key_en_i & ~key_sync_i));
  assign mode     = sense_e'(level_mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= (pend_q & ~ack_i) | any_fall;
  end

  assign req_o = en_i & (pend_q | ((mode == SENSE_LEVEL) & any_low));

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !any_fall |=> !pend_q); // R9
  AST_LEVEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_mode_i && en_i && !irq_sync |-> req_o); // R10
endmodule

// File: rtl/gpio_keyscan_port.sv
module gpio_keyscan_port #(
  parameter int unsigned  W        = 8,
  parameter int unsigned  ADDR_W   = 3,
  parameter int unsigned  STAGES   = 2,
  parameter logic [W-1:0] KEY_OPT  = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [W-1:0]      bus_wdata_i,
  output logic [W-1:0]      bus_rdata_o,
  input  logic [W-1:0]      pa_in_i,
  output logic [W-1:0]      pa_out_o,
  output logic [W-1:0]      pa_oe_o,
  input  logic [W-1:0]      pb_in_i,
  output logic [W-1:0]      pb_out_o,
  output logic [W-1:0]      pb_oe_o,
  output logic [W-1:0]      pb_pullup_o,
  input  logic              irq_ni,
  input  logic              irq_level_mode_i,
  input  logic              irq_en_i,
  input  logic              irq_ack_i,
  output logic              irq_req_o
);
  import gpio_kbd_pkg::*;

  localparam logic [ADDR_W-1:0] A_PA_DATA = ADDR_W'(OFF_PA_DATA);
  localparam logic [ADDR_W-1:0] A_PB_DATA = ADDR_W'(OFF_PB_DATA);
  localparam logic [ADDR_W-1:0] A_PA_DIR  = ADDR_W'(OFF_PA_DIR);
  localparam logic [ADDR_W-1:0] A_PB_DIR  = ADDR_W'(OFF_PB_DIR);

  logic [W-1:0] pa_sync, pb_sync;
  logic [W-1:0] key_en;
  logic         mapped;

  gpio_bank #(.W(W), .ADDR_W(ADDR_W), .STAGES(STAGES),
              .DATA_ADDR(A_PA_DATA), .DIR_ADDR(A_PA_DIR)) u_bank_a (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (bus_addr_i),
    .wr_i   (bus_wr_i),
    .wdata_i(bus_wdata_i),
    .pin_i  (pa_in_i),
    .out_o  (pa_out_o),
    .oe_o   (pa_oe_o),
    .sync_o (pa_sync)
  );

  gpio_bank #(.W(W), .ADDR_W(ADDR_W), .STAGES(STAGES),
              .DATA_ADDR(A_PB_DATA), .DIR_ADDR(A_PB_DIR)) u_bank_b (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (bus_addr_i),
    .wr_i   (bus_wr_i),
    .wdata_i(bus_wdata_i),
    .pin_i  (pb_in_i),
    .out_o  (pb_out_o),
    .oe_o   (pb_oe_o),
    .sync_o (pb_sync)
  );

  assign key_en      = KEY_OPT & ~pb_oe_o;
  assign pb_pullup_o = KEY_OPT;

  gpio_key_irq #(.W(W), .STAGES(STAGES)) u_key_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .key_sync_i  (pb_sync),
    .key_en_i    (key_en),
    .irq_ni      (irq_ni),
    .level_mode_i(irq_level_mode_i),
    .en_i        (irq_en_i),
    .ack_i       (irq_ack_i),
    .req_o       (irq_req_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      A_PA_DATA: bus_rdata_o = (pa_oe_o & pa_out_o) | (~pa_oe_o & pa_sync);
      A_PB_DATA: bus_rdata_o = (pb_oe_o & pb_out_o) | (~pb_oe_o & pb_sync);
      A_PA_DIR:  bus_rdata_o = pa_oe_o;
      A_PB_DIR:  bus_rdata_o = pb_oe_o;
      default:   bus_rdata_o = '0;
    endcase
  end

  assign mapped = (bus_addr_i == A_PA_DATA) || (bus_addr_i == A_PB_DATA) ||
                  (bus_addr_i == A_PA_DIR)  || (bus_addr_i == A_PB_DIR);

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |-> bus_rdata_o == '0); // R5
  AST_REQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_req_o); // R11
endmodule

// File: tb/gpio_keyscan_port_bench.sv
module gpio_keyscan_port_bench;
  localparam int unsigned W = 8;
  localparam logic [W-1:0] OPT = 8'hA5;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [2:0]   bus_addr_i = '0;
  logic         bus_wr_i = 1'b0;
  logic [W-1:0] bus_wdata_i = '0;
  logic [W-1:0] bus_rdata_o;
  logic [W-1:0] pa_in_i = '1, pa_out_o, pa_oe_o;
  logic [W-1:0] pb_in_i = '1, pb_out_o, pb_oe_o, pb_pullup_o;
  logic         irq_ni = 1'b1, irq_level_mode_i = 1'b0, irq_en_i = 1'b0;
  logic         irq_ack_i = 1'b0, irq_req_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  gpio_keyscan_port #(.W(W), .ADDR_W(3), .STAGES(2), .KEY_OPT(OPT)) u_gpio_keyscan_port (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o),
    .pa_in_i(pa_in_i), .pa_out_o(pa_out_o), .pa_oe_o(pa_oe_o),
    .pb_in_i(pb_in_i), .pb_out_o(pb_out_o), .pb_oe_o(pb_oe_o),
    .pb_pullup_o(pb_pullup_o),
    .irq_ni(irq_ni), .irq_level_mode_i(irq_level_mode_i), .irq_en_i(irq_en_i),
    .irq_ack_i(irq_ack_i), .irq_req_o(irq_req_o)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(negedge clk_i);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [W-1:0] exp, input string req);
    @(negedge clk_i);
    bus_addr_i = a;
    #1 chk(req, bus_rdata_o, exp);
  endtask

  task automatic ack();
    @(negedge clk_i);
    irq_ack_i = 1'b1;
    @(negedge clk_i);
    irq_ack_i = 1'b0;
    cyc(1);
  endtask

  task automatic t_reset();
    chk("R3 oe a", pa_oe_o, 8'h00);
    chk("R3 oe b", pb_oe_o, 8'h00);
    chk("R6 req idle", {7'd0, irq_req_o}, 8'h00);
    chk("R13 pullup", pb_pullup_o, OPT);
    rd_chk(3'd5, 8'h00, "R3 dir b");
  endtask

  task automatic t_decode();
    wr(3'd0, 8'h3C); wr(3'd4, 8'hFF);
    wr(3'd1, 8'h5A); wr(3'd5, 8'h0F);
    chk("R2 pa_out", pa_out_o, 8'h3C);
    chk("R2 pa_oe", pa_oe_o, 8'hFF);
    chk("R2 pb_oe", pb_oe_o, 8'h0F);
    chk("R2 pb_out", pb_out_o, 8'h5A);
    rd_chk(3'd0, 8'h3C, "R1 pa data");
    rd_chk(3'd4, 8'hFF, "R1 pa dir");
    rd_chk(3'd5, 8'h0F, "R1 pb dir");
  endtask

  task automatic t_readback();
    pb_in_i = 8'hC3;
    cyc(3);
    rd_chk(3'd1, 8'hCA, "R4 mixed readback");
    pb_in_i = 8'hFF;
    cyc(3);
    rd_chk(3'd1, 8'hFA, "R4 inputs high");
  endtask

  task automatic t_unmapped();
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    for (int a = 2; a < 8; a++)
      if (a == 2 || a == 3 || a == 6 || a == 7) rd_chk(3'(a), 8'h00, "R5 unmapped read");
    rd_chk(3'd0, 8'h3C, "R5 pa data kept");
    rd_chk(3'd5, 8'h0F, "R5 pb dir kept");
    chk("R5 pb_out kept", pb_out_o, 8'h5A);
  endtask

  task automatic t_reset_keep();
    @(negedge clk_i); rst_ni = 1'b0;
    cyc(2);
    chk("R3 oe a cleared", pa_oe_o, 8'h00);
    chk("R3 oe b cleared", pb_oe_o, 8'h00);
    rst_ni = 1'b1;
    cyc(1);
    chk("R3 latch a kept", pa_out_o, 8'h3C);
    chk("R3 latch b kept", pb_out_o, 8'h5A);
    wr(3'd4, 8'hFF);
    rd_chk(3'd0, 8'h3C, "R3 latch readback");
  endtask

  task automatic t_key_edge();
    irq_level_mode_i = 1'b0; irq_en_i = 1'b1;
    ack();
    chk("R6 clean start", {7'd0, irq_req_o}, 8'h00);
    pb_in_i[0] = 1'b0;
    cyc(4);
    chk("R6 key edge", {7'd0, irq_req_o}, 8'h01);
    pb_in_i[0] = 1'b1;
    cyc(4);
    chk("R9 sticky", {7'd0, irq_req_o}, 8'h01);
    ack();
    chk("R9 ack clears", {7'd0, irq_req_o}, 8'h00);
  endtask

  task automatic t_masked();
    pb_in_i[1] = 1'b0;
    cyc(5);
    chk("R7 option clear", {7'd0, irq_req_o}, 8'h00);
    pb_in_i[1] = 1'b1;
    wr(3'd5, 8'h01);
    pb_in_i[0] = 1'b0;
    cyc(5);
    chk("R7 output pin", {7'd0, irq_req_o}, 8'h00);
    pb_in_i[0] = 1'b1;
    cyc(4);
    wr(3'd5, 8'h00);
    cyc(4);
    chk("R7 restore", {7'd0, irq_req_o}, 8'h00);
  endtask

  task automatic t_ext_irq();
    irq_ni = 1'b0;
    cyc(4);
    chk("R8 ext edge", {7'd0, irq_req_o}, 8'h01);
    ack();
    cyc(2);
    chk("R9 held low after ack", {7'd0, irq_req_o}, 8'h00);
    irq_ni = 1'b1;
    cyc(4);
  endtask

  task automatic t_level();
    irq_level_mode_i = 1'b1;
    pb_in_i[2] = 1'b0;
    cyc(4);
    ack();
    cyc(2);
    chk("R10 level hold", {7'd0, irq_req_o}, 8'h01);
    pb_in_i[2] = 1'b1;
    cyc(4);
    ack();
    chk("R10 release", {7'd0, irq_req_o}, 8'h00);
    irq_level_mode_i = 1'b0;
  endtask

  task automatic t_gate();
    irq_en_i = 1'b0;
    pb_in_i[5] = 1'b0;
    cyc(4);
    pb_in_i[5] = 1'b1;
    cyc(4);
    chk("R11 gated", {7'd0, irq_req_o}, 8'h00);
    @(negedge clk_i); irq_en_i = 1'b1;
    #1 chk("R11 pending kept", {7'd0, irq_req_o}, 8'h01);
    ack();
  endtask

  task automatic t_switch();
    wr(3'd1, 8'h00);
    wr(3'd5, 8'h01);
    pb_in_i[0] = 1'b0;
    cyc(4);
    ack();
    wr(3'd5, 8'h00);
    cyc(5);
    chk("R12 no spurious edge", {7'd0, irq_req_o}, 8'h00);
    pb_in_i[0] = 1'b1;
    cyc(4);
  endtask

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    t_reset();
    t_decode();
    t_readback();
    t_unmapped();
    t_reset_keep();
    t_key_edge();
    t_masked();
    t_ext_irq();
    t_level();
    t_gate();
    t_switch();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule